// File: doc/BRIEF.md
# Modular Fibonacci Hash Engine

This block hashes a stream of 16-bit words, which are two text bytes each, into a 40-bit digest. It holds two 20-bit state registers, X and Y, and a small carry register. On every step it adds both registers, the carry, the input word and a fixed offset. It then folds the total back below a modulus that is not a power of two. The quotient of that division becomes the carry for the next step, so overflow is re-injected and not discarded. Y takes the old value of X, in the manner of a Fibonacci recurrence.

A start pulse seeds the state. Words then arrive on a valid/ready stream, and the final word carries a last flag. After that word, the engine runs two more steps with zero data, so that the final word spreads into both registers. It then raises done and holds the digest until the next start.

Top module: `modfib_hash`

## Requirements
- R1: Out of reset, done and in_ready are low and digest equals {SEED_Y, SEED_X} = {0x3DB6D, 0x5B6DB}.
- R2: A start pulse loads X=0x5B6DB, Y=0x3DB6D and carry 0, and it clears done. From the next cycle in_ready is high. If start coincides with an input word or a flush step, start wins and that word or step has no effect.
- R3: Each step forms S = X + Y + carry + word + 513493, then sets carry to floor(S / 741454), X to S mod 741454, and Y to the old X.
- R4: X and Y always stay below 741454, and the carry never exceeds 2.
- R5: A word is consumed only at a clock edge where in_valid and in_ready are both high. in_valid while in_ready is low, whether before any start or after done, leaves the digest unchanged.
- R6: After the edge that consumes a word with in_last high, in_ready is low for two cycles. During those cycles two steps run with word = 0, and the offset is still added. done then goes high on the following cycle.
- R7: digest is {Y, X}, with Y in bits 39:20 and X in bits 19:0. While done is high and no start arrives, done and digest hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new hash; reseeds the state |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Engine accepts a word this cycle |
| in_data | input | 16 | Input word (two bytes) |
| in_last | input | 1 | Marks the final word of the message |
| digest | output | 40 | Hash state {Y, X} |
| done | output | 1 | Digest is final and held |

## Verification
The bench follows the digest after every step against a model that works with plain division and remainder. That catches a fold that drops the quotient, or one that mishandles a sum at or above twice the modulus. It sends words near 0xFFFF back to back to push the sums high, and zero words to show the offset at work. It aims stimulus at a start that coincides with a valid word, at gaps in in_valid, and at valid held high before start or after done. A design that gave priority to the word over start, or that took input outside the absorb phase, would move the digest there. It also times the two flush steps and the rise of done, which exposes a flush count that is off by one or an in_ready left high during the flush.

// File: rtl/modfib_pkg.sv
package modfib_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ABSORB = 2'd1,
    PH_FLUSH  = 2'd2,
    PH_DONE   = 2'd3
  } phase_t;

  // Raw five-term addition, kept wide; callers truncate to their sum width.
  function automatic logic [31:0] mf_raw_sum(input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] cin, input logic [31:0] word,
                                             input logic [31:0] ofs);
    return a + b + cin + word + ofs;
  endfunction

  // Largest quotient a single fold can produce for the given widths.
  function automatic int mf_max_quot(input int modv, input int data_w, input int ofs);
    int bound;
    bound = 2 * (modv - 1) + 3 + ((1 << data_w) - 1) + ofs;
    return bound / modv;
  endfunction

endpackage

// File: rtl/modfib_fold.sv
module modfib_fold #(
  parameter int W     = 20,
  parameter int MOD   = 741454,
  parameter int SUM_W = 22,
  parameter int QMAX  = 2,
  parameter int Q_W   = 2
) (
  input  logic [SUM_W-1:0] sum_i,
  output logic [W-1:0]     rem_o,
  output logic [Q_W-1:0]   quot_o
);

  // Thermometer of "sum reached k*MOD", one comparator per multiple.
  logic [QMAX-1:0]  reach;
  logic [SUM_W-1:0] cand [QMAX+1];

  for (genvar k = 1; k <= QMAX; k++) begin : g_cmp
    assign reach[k-1] = (sum_i >= SUM_W'(k * MOD));
  end

  for (genvar k = 0; k <= QMAX; k++) begin : g_cand
    assign cand[k] = sum_i - SUM_W'(k * MOD);
  end

  always_comb begin
    quot_o = '0;
    for (int k = 0; k < QMAX; k++) begin
      quot_o = quot_o + Q_W'(reach[k]);
    end
  end

  assign rem_o = W'(cand[quot_o]);

endmodule

// File: rtl/modfib_step.sv
module modfib_step
  import modfib_pkg::*;
#(
  parameter int W      = 20,
  parameter int DATA_W = 16,
  parameter int MOD    = 741454,
  parameter int OFFSET = 513493,
  parameter int SUM_W  = 22,
  parameter int QMAX   = 2,
  parameter int Q_W    = 2
) (
  input  logic [W-1:0]      x_i,
  input  logic [W-1:0]      y_i,
  input  logic [Q_W-1:0]    c_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              zero_i,
  output logic [W-1:0]      x_next_o,
  output logic [Q_W-1:0]    c_next_o
);

  logic [DATA_W-1:0] word;
  logic [SUM_W-1:0]  total;

  assign word  = zero_i ? '0 : data_i;
  assign total = SUM_W'(mf_raw_sum(32'(x_i), 32'(y_i), 32'(c_i), 32'(word), 32'(OFFSET)));

  modfib_fold #(
    .W(W), .MOD(MOD), .SUM_W(SUM_W), .QMAX(QMAX), .Q_W(Q_W)
  ) u_fold (
    .sum_i (total),
    .rem_o (x_next_o),
    .quot_o(c_next_o)
  );

endmodule

// File: rtl/modfib_ctrl.sv
module modfib_ctrl
  import modfib_pkg::*;
#(
  parameter int FLUSH_STEPS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic step_en,
  output logic step_zero,
  output logic load,
  output logic done
);

  localparam int FC_W     = (FLUSH_STEPS > 1) ? $clog2(FLUSH_STEPS) : 1;
  localparam int LAST_CNT = (FLUSH_STEPS > 0) ? FLUSH_STEPS - 1 : 0;

  phase_t          phase_q, phase_d;
  logic [FC_W-1:0] cnt_q, cnt_d;
  logic            take_word;
  logic            flush_end;

  assign in_ready  = (phase_q == PH_ABSORB);
  assign take_word = in_ready && in_valid && !start;
  assign flush_end = (phase_q == PH_FLUSH) && (cnt_q == FC_W'(LAST_CNT));
  assign step_en   = !start && (take_word || phase_q == PH_FLUSH);
  assign step_zero = (phase_q == PH_FLUSH);
  assign load      = start;
  assign done      = (phase_q == PH_DONE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (start) begin
      phase_d = PH_ABSORB;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_ABSORB: if (take_word && in_last) begin
          phase_d = (FLUSH_STEPS > 0) ? PH_FLUSH : PH_DONE;
          cnt_d   = '0;
        end
        PH_FLUSH: begin
          cnt_d = cnt_q + 1'b1;
          if (flush_end) phase_d = PH_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // R2: start leaves the engine ready and not done
  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (in_ready && !done));

  // R6: the last accepted word closes the input port
  a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && !start) |=> !in_ready);

  // R6: done only rises out of the flush phase
  a_r6_done_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(flush_end));

  // R7: done holds until a new start
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

endmodule

// File: rtl/modfib_state.sv
module modfib_state #(
  parameter int             W      = 20,
  parameter int             MOD    = 741454,
  parameter int             QMAX   = 2,
  parameter int             Q_W    = 2,
  parameter logic [W-1:0]   SEED_X = 20'h5B6DB,
  parameter logic [W-1:0]   SEED_Y = 20'h3DB6D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step_en,
  input  logic [W-1:0]   x_next,
  input  logic [Q_W-1:0] c_next,
  output logic [W-1:0]   x_q,
  output logic [W-1:0]   y_q,
  output logic [Q_W-1:0] c_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= SEED_X;
      y_q <= SEED_Y;
      c_q <= '0;
    end else if (load) begin
      x_q <= SEED_X;
      y_q <= SEED_Y;
      c_q <= '0;
    end else if (step_en) begin
      x_q <= x_next;
      y_q <= x_q;
      c_q <= c_next;
    end
  end

  // R4: state registers stay inside the residue range
  a_r4_x_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    x_q < W'(MOD));
  a_r4_y_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    y_q < W'(MOD));
  a_r4_carry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    c_q <= Q_W'(QMAX));

  // R3: Fibonacci shift of X into Y on every step
  a_r3_y_follows_x: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load) |=> (y_q == $past(x_q)));

  // R2: start reseeds everything
  a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (x_q == SEED_X && y_q == SEED_Y && c_q == '0));

  // R5: no step, no change
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !load) |=> ($stable(x_q) && $stable(y_q) && $stable(c_q)));

endmodule

// File: rtl/modfib_hash.sv
module modfib_hash
  import modfib_pkg::*;
#(
  parameter int           W           = 20,
  parameter int           DATA_W      = 16,
  parameter int           MOD         = 741454,
  parameter int           OFFSET      = 513493,
  parameter int           FLUSH_STEPS = 2,
  parameter logic [W-1:0] SEED_X      = 20'h5B6DB,
  parameter logic [W-1:0] SEED_Y      = 20'h3DB6D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic [2*W-1:0]    digest,
  output logic              done
);

  localparam int QMAX    = mf_max_quot(MOD, DATA_W, OFFSET);
  localparam int Q_W     = (QMAX > 1) ? $clog2(QMAX + 1) : 1;
  localparam int MAX_SUM = 2 * (MOD - 1) + QMAX + ((1 << DATA_W) - 1) + OFFSET;
  localparam int SUM_W   = $clog2(MAX_SUM + 1);

  logic           step_en, step_zero, load;
  logic [W-1:0]   x_q, y_q, x_next;
  logic [Q_W-1:0] c_q, c_next;

  modfib_ctrl #(.FLUSH_STEPS(FLUSH_STEPS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .step_en  (step_en),
    .step_zero(step_zero),
    .load     (load),
    .done     (done)
  );

  modfib_step #(
    .W(W), .DATA_W(DATA_W), .MOD(MOD), .OFFSET(OFFSET),
    .SUM_W(SUM_W), .QMAX(QMAX), .Q_W(Q_W)
  ) u_step (
    .x_i     (x_q),
    .y_i     (y_q),
    .c_i     (c_q),
    .data_i  (in_data),
    .zero_i  (step_zero),
    .x_next_o(x_next),
    .c_next_o(c_next)
  );

  modfib_state #(
    .W(W), .MOD(MOD), .QMAX(QMAX), .Q_W(Q_W),
    .SEED_X(SEED_X), .SEED_Y(SEED_Y)
  ) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step_en(step_en),
    .x_next (x_next),
    .c_next (c_next),
    .x_q    (x_q),
    .y_q    (y_q),
    .c_q    (c_q)
  );

  assign digest = {y_q, x_q};

  // R7: a finished digest does not move without a start
  a_r7_digest_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(digest));

endmodule

// File: tb/modfib_hash_tb.sv
`timescale 1ns/1ps
module modfib_hash_tb_top;

  localparam longint M    = 741454;
  localparam longint OFS  = 513493;
  localparam logic [19:0] SX = 20'h5B6DB;
  localparam logic [19:0] SY = 20'h3DB6D;

  // {length, w0, w1, w2, w3}
  localparam logic [67:0] VECS [6] = '{
    {4'd1, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {4'd1, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000},
    {4'd2, 16'h6162, 16'h6364, 16'h0000, 16'h0000},
    {4'd4, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {4'd3, 16'h2020, 16'h0A0D, 16'h7E7E, 16'h0000},
    {4'd4, 16'h0000, 16'h0001, 16'h8000, 16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_last = 1'b0;
  logic [39:0] digest;
  logic        done;

  int n_tests = 0;
  int n_fail  = 0;
  longint mx, my, mc;

  always #10 clk = ~clk;

  modfib_hash dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .digest(digest), .done(done)
  );

  function automatic logic [39:0] model_digest();
    return {my[19:0], mx[19:0]};
  endfunction

  task automatic model_seed();
    mx = longint'(SX); my = longint'(SY); mc = 0;
  endtask

  task automatic model_step(input longint word);
    longint s;
    s  = mx + my + mc + word + OFS;
    mc = s / M;
    my = mx;
    mx = s % M;
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    model_seed();
    check(digest == model_digest(), "R2 seed", 64'(digest), 64'(model_digest()));
    check(in_ready && !done, "R2 ready", {62'd0, in_ready, done}, 64'd2);
  endtask

  task automatic run_vec(input logic [67:0] v);
    int len;
    len = int'(v[67:64]);
    do_start();
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = v[63 - 16*i -: 16];
      in_last  = (i == len - 1);
      @(negedge clk);
      model_step(longint'(v[63 - 16*i -: 16]));
      check(digest == model_digest(), "R3 step", 64'(digest), 64'(model_digest()));
      check(mx < M && my < M && mc <= 2, "R4 range", 64'(mc), 64'd2);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    check(!in_ready && !done, "R6 flush1 ready", {62'd0, in_ready, done}, 64'd0);
    @(negedge clk);
    model_step(0);
    check(digest == model_digest(), "R6 flush1", 64'(digest), 64'(model_digest()));
    check(!in_ready && !done, "R6 flush2 ready", {62'd0, in_ready, done}, 64'd0);
    @(negedge clk);
    model_step(0);
    check(digest == model_digest(), "R6 flush2", 64'(digest), 64'(model_digest()));
    check(done && !in_ready, "R6 done", {62'd0, in_ready, done}, 64'd1);
  endtask

  initial begin
    #4_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_seed();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(digest == {SY, SX}, "R1 digest", 64'(digest), 64'({SY, SX}));
    check(!done && !in_ready, "R1 flags", {62'd0, in_ready, done}, 64'd0);

    // R5: valid before any start is ignored
    in_valid = 1'b1; in_data = 16'h4242; in_last = 1'b1;
    repeat (2) @(negedge clk);
    check(digest == {SY, SX}, "R5 idle ignore", 64'(digest), 64'({SY, SX}));
    in_valid = 1'b0; in_last = 1'b0;

    foreach (VECS[i]) run_vec(VECS[i]);

    // R7 / R5: done holds, input ignored
    begin
      logic [39:0] held;
      held = digest;
      in_valid = 1'b1; in_data = 16'h1234; in_last = 1'b0;
      repeat (4) @(negedge clk);
      check(digest == held, "R7 hold", 64'(digest), 64'(held));
      check(done && !in_ready, "R7 done held", {62'd0, in_ready, done}, 64'd1);
      in_valid = 1'b0;
    end

    // R5: gaps in valid during absorb leave state alone
    do_start();
    in_valid = 1'b1; in_data = 16'h00FF; in_last = 1'b0;
    @(negedge clk);
    model_step(16'h00FF);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(digest == model_digest(), "R5 gap", 64'(digest), 64'(model_digest()));

    // R2: start coinciding with a valid word wins
    in_valid = 1'b1; in_data = 16'hABCD; start = 1'b1;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    model_seed();
    check(digest == model_digest(), "R2 start priority", 64'(digest), 64'(model_digest()));
    check(in_ready && !done, "R2 start priority ready", {62'd0, in_ready, done}, 64'd2);

    // R2: start during the flush cancels it
    in_valid = 1'b1; in_data = 16'h7777; in_last = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    model_seed();
    check(digest == model_digest(), "R2 start in flush", 64'(digest), 64'(model_digest()));
    @(negedge clk);
    check(!done && in_ready, "R2 flush cancelled", {62'd0, in_ready, done}, 64'd2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule